// File: doc/BRIEF.md
# Adaptive Stuck-At Fault Localizer

This block is a small sequential test controller that works out which single stuck-at fault, if any, sits on a two-input AND gate under test. Once `start` is pulsed, it drives a two-bit stimulus onto the gate inputs and waits for the gate to settle. It then samples the gate output and compares it with the fault-free AND of that stimulus. Each comparison shrinks the set of remaining candidates, and the controller picks the next stimulus from that outcome. The search therefore adapts, and every case is settled in at most three vectors, where an exhaustive sweep would take four.

Seven conditions are possible: the good gate, stuck-at-1 on either input or on the output, and stuck-at-0 on either input or on the output. The three stuck-at-0 conditions give the same response to every stimulus, so the controller reports them as a single class. The final answer is a five-bit one-hot code. It stays on the output, with `done` high, until the next `start`. The gate under test is an external combinational circuit: its inputs come from `vecA`/`vecB` and its output comes back on `yIn`.

Top module: `fault_localizer`

## Requirements
- R1: During and after synchronous reset, `done` is 0, `result` is 00000 and `vecA`/`vecB` are both 0.
- R2: On the clock edge that sees `start` high while no search is running, the controller clears `done` and `result` and drives the first vector a=1'b0, b=1'b1.
- R3: Each vector is held for SETTLE_CYCLES clocks. `yIn` is sampled on the last of those edges, which is one clock after the vector appears with the default value.
- R4: A sample fails when `yIn` differs from `vecA & vecB` for the vector being applied, and passes otherwise.
- R5: If the first vector fails, the second vector is a=1, b=0. A fail then reports stuck-at-1 on the output, and a pass reports stuck-at-1 on input a.
- R6: If the first vector passes, the second vector is a=1, b=0, and a fail reports stuck-at-1 on input b. On a pass, a third vector a=1, b=1 follows: a pass reports fault-free and a fail reports the stuck-at-0 class.
- R7: `result` is one-hot: bit 0 fault-free, bit 1 stuck-at-1 on a, bit 2 stuck-at-1 on b, bit 3 stuck-at-1 on the output, bit 4 any stuck-at-0.
- R8: A search applies at most three vectors. `done` rises on the same edge that samples the last vector, so done follows start by (number of vectors × SETTLE_CYCLES) clocks.
- R9: Once `done` is high, it and `result` stay unchanged until `start` is seen again. A new `start` from that state begins a fresh search without a reset.
- R10: `start` pulses during a running search are ignored. The vector sequence and the result are the same as without them.
- R11: Outside a running search, `vecA`/`vecB` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a search when idle or finished |
| yIn | input | 1 | Output of the gate under test |
| vecA | output | 1 | Stimulus to gate input a |
| vecB | output | 1 | Stimulus to gate input b |
| done | output | 1 | High once the search has settled on a class |
| result | output | 5 | One-hot fault class |

## Verification
The bench builds the block with SETTLE_CYCLES at its default of 1. At that value, every vector-to-vector transition and the done latency land on single, countable clock edges, so the bench checks the exact vector sequence and the exact count of two or three clocks for each of the seven injected conditions. With settling reduced to one edge, the sample sits directly beside the vector change. A sampling or hold error of a single cycle therefore shows up as a wrong vector or a wrong class.

// File: rtl/fault_loc_pkg.sv
package fault_loc_pkg;

  localparam int RES_W = 5;

  // one-hot result bit positions
  localparam int RES_GOOD  = 0;
  localparam int RES_SA1_A = 1;
  localparam int RES_SA1_B = 2;
  localparam int RES_SA1_Y = 3;
  localparam int RES_SA0   = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ctlState_t;

  typedef enum logic [1:0] {
    STEP_FIRST      = 2'd0,
    STEP_AFTER_FAIL = 2'd1,
    STEP_AFTER_PASS = 2'd2,
    STEP_LAST       = 2'd3
  } step_t;

  // vector encoding: {a, b}
  localparam logic [1:0] VEC_NONE = 2'b00;
  localparam logic [1:0] VEC_01   = 2'b01;
  localparam logic [1:0] VEC_10   = 2'b10;
  localparam logic [1:0] VEC_11   = 2'b11;

  typedef struct packed {
    logic             clear;
    logic             loadVec;
    logic [1:0]       nextVec;
    logic             finish;
    logic [RES_W-1:0] code;
  } ctlStrobe_t;

  function automatic logic [RES_W-1:0] oneHot(input int pos);
    logic [RES_W-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/fault_loc_datapath.sv
module fault_loc_datapath
  import fault_loc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobe_t       strobe,
  input  logic             yIn,
  output logic             vecA,
  output logic             vecB,
  output logic             mismatch,
  output logic             done,
  output logic [RES_W-1:0] result
);

  logic [1:0] vecReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      vecReg <= VEC_NONE;
      done   <= 1'b0;
      result <= '0;
    end else begin
      if (strobe.clear) begin
        done   <= 1'b0;
        result <= '0;
      end
      if (strobe.loadVec) vecReg <= strobe.nextVec;
      if (strobe.finish) begin
        done   <= 1'b1;
        result <= strobe.code;
        vecReg <= VEC_NONE;
      end
    end
  end

  assign vecA     = vecReg[1];
  assign vecB     = vecReg[0];
  assign mismatch = yIn != (vecReg[1] & vecReg[0]);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !strobe.clear) |=> (done && $stable(result)));

  // R7
  onehot_result_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones(result) == 1));

  // R2
  cleared_result_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> (result == '0));

endmodule

// File: rtl/fault_loc_control.sv
module fault_loc_control
  import fault_loc_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       mismatch,
  output ctlStrobe_t strobe,
  output logic       busy
);

  ctlState_t state;
  step_t     step;
  step_t     nextStep;
  logic      sampleNow;
  logic      running;

  assign running = (state == ST_RUN);
  assign busy    = running;

  generate
    if (SETTLE_CYCLES <= 1) begin : g_noWait
      assign sampleNow = running;
    end else begin : g_wait
      localparam int WAIT_W = $clog2(SETTLE_CYCLES);
      localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(SETTLE_CYCLES - 1);
      logic [WAIT_W-1:0] waitCnt;
      always_ff @(posedge clk) begin
        if (rst || strobe.loadVec || !running) waitCnt <= '0;
        else if (waitCnt != WAIT_LAST)          waitCnt <= waitCnt + 1'b1;
      end
      assign sampleNow = running && (waitCnt == WAIT_LAST);
    end
  endgenerate

  always_comb begin
    strobe   = '0;
    nextStep = step;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strobe.clear   = 1'b1;
          strobe.loadVec = 1'b1;
          strobe.nextVec = VEC_01;
          nextStep       = STEP_FIRST;
        end
      end
      ST_RUN: begin
        if (sampleNow) begin
          unique case (step)
            STEP_FIRST: begin
              strobe.loadVec = 1'b1;
              strobe.nextVec = VEC_10;
              nextStep       = mismatch ? STEP_AFTER_FAIL : STEP_AFTER_PASS;
            end
            STEP_AFTER_FAIL: begin
              strobe.finish = 1'b1;
              strobe.code   = mismatch ? oneHot(RES_SA1_Y) : oneHot(RES_SA1_A);
            end
            STEP_AFTER_PASS: begin
              if (mismatch) begin
                strobe.finish = 1'b1;
                strobe.code   = oneHot(RES_SA1_B);
              end else begin
                strobe.loadVec = 1'b1;
                strobe.nextVec = VEC_11;
                nextStep       = STEP_LAST;
              end
            end
            STEP_LAST: begin
              strobe.finish = 1'b1;
              strobe.code   = mismatch ? oneHot(RES_SA0) : oneHot(RES_GOOD);
            end
            default: ;
          endcase
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      step  <= STEP_FIRST;
    end else begin
      step <= nextStep;
      if (strobe.finish)       state <= ST_DONE;
      else if (strobe.loadVec) state <= ST_RUN;
    end
  end

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (running && !sampleNow) |=> (running && $stable(step)));

  // R8
  last_step_finishes_chk: assert property (@(posedge clk) disable iff (rst)
    (sampleNow && step == STEP_LAST) |=> (state == ST_DONE));

endmodule

// File: rtl/fault_localizer.sv
module fault_localizer
  import fault_loc_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             yIn,
  output logic             vecA,
  output logic             vecB,
  output logic             done,
  output logic [RES_W-1:0] result
);

  ctlStrobe_t strobe;
  logic       mismatch;
  logic       busy;

  fault_loc_control #(.SETTLE_CYCLES(SETTLE_CYCLES)) ctl_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mismatch (mismatch),
    .strobe   (strobe),
    .busy     (busy)
  );

  fault_loc_datapath dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .yIn      (yIn),
    .vecA     (vecA),
    .vecB     (vecB),
    .mismatch (mismatch),
    .done     (done),
    .result   (result)
  );

  // R2
  first_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (!vecA && vecB && !done));

  // R11
  idle_vector_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!vecA && !vecB));

endmodule

// File: tb/fault_localizer_tb_top.sv
module fault_localizer_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic       yIn;
  logic       vecA, vecB, done;
  logic [4:0] result;
  int         faultSel;

  int testsRun  = 0;
  int testsFail = 0;
  bit finished  = 1'b0;

  always #2 clk = ~clk;

  fault_localizer dut_i (
    .clk(clk), .rst(rst), .start(start), .yIn(yIn),
    .vecA(vecA), .vecB(vecB), .done(done), .result(result)
  );

  // gate under test: 0 good,1 sa1 a,2 sa1 b,3 sa1 y,4 sa0 a,5 sa0 b,6 sa0 y
  always_comb begin
    logic ga, gb, gy;
    ga = vecA; gb = vecB;
    if (faultSel == 1) ga = 1'b1;
    if (faultSel == 4) ga = 1'b0;
    if (faultSel == 2) gb = 1'b1;
    if (faultSel == 5) gb = 1'b0;
    gy = ga & gb;
    if (faultSel == 3) gy = 1'b1;
    if (faultSel == 6) gy = 1'b0;
    yIn = gy;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expCode(input int f);
    case (f)
      0: return 5'b00001;
      1: return 5'b00010;
      2: return 5'b00100;
      3: return 5'b01000;
      default: return 5'b10000;
    endcase
  endfunction

  function automatic int expLen(input int f);
    return (f == 1 || f == 2 || f == 3) ? 2 : 3;
  endfunction

  // R4 R5 R6: vectors are {a,b}: 01, 10, then 11 when needed
  function automatic int expVec(input int idx);
    case (idx)
      0: return 1;
      1: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic runSearch(input int f, input bit pokeStart, input string tag);
    int seen[4];
    int cycles;
    faultSel = f;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (!done && cycles < 20) begin
      if (cycles < 4) seen[cycles] = {vecA, vecB};
      if (pokeStart && cycles == 0) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cycles++;
    end
    // R8: done after N vectors x 1 clock
    check(cycles == expLen(f), "R8", {tag, " latency"}, cycles, expLen(f));
    for (int i = 0; i < expLen(f) && i < cycles; i++)
      // R2 R3 R5 R6
      check(seen[i] == expVec(i), (i == 0) ? "R2" : "R6", {tag, " vector"}, seen[i], expVec(i));
    // R7 result code, R5/R6 classification
    check(done && result == expCode(f), (f == 1 || f == 3) ? "R5" : "R7",
          {tag, " result"}, result, expCode(f));
    // R11
    check({vecA, vecB} == 2'b00, "R11", {tag, " idle vector"}, {vecA, vecB}, 0);
  endtask

  task automatic testReset();
    rst = 1'b1; start = 1'b0; faultSel = 0;
    repeat (3) @(negedge clk);
    check(!done && result == 0 && {vecA, vecB} == 0, "R1", "reset state",
          {done, result, vecA, vecB}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!done && result == 0, "R1", "after reset", {done, result}, 0);
  endtask

  task automatic testAllFaults();
    for (int f = 0; f < 7; f++) runSearch(f, 1'b0, $sformatf("fault%0d", f));
  endtask

  task automatic testHold();
    logic [4:0] held;
    runSearch(3, 1'b0, "hold-setup");
    held = result;
    faultSel = 0;
    repeat (10) @(negedge clk);
    check(done && result == held, "R9", "hold", result, held);
    check({vecA, vecB} == 2'b00, "R11", "hold vector", {vecA, vecB}, 0);
  endtask

  task automatic testRestartClears();
    @(negedge clk);
    faultSel = 4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done && result == 0, "R2", "restart clears", {done, result}, 0);
    check({vecA, vecB} == 2'b01, "R2", "restart vector", {vecA, vecB}, 1);
    while (!done) @(negedge clk);
    check(result == 5'b10000, "R9", "restart result", result, 5'b10000);
  endtask

  task automatic testBusyStart();
    runSearch(0, 1'b1, "R10 busy start good");
    runSearch(2, 1'b1, "R10 busy start sa1b");
  endtask

  initial begin
    testReset();
    testAllFaults();
    testHold();
    testRestartClears();
    testBusyStart();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

endmodule